// File: doc/BRIEF.md
# Dual-Memory Chip-Select Mapper

This block converts the chip-select field held in a quad SPI controller's configuration into the active-low select lines of up to two serial flash memories. The two memories can share the data path in parallel, with one select driving both devices at once. They can also be stacked on a single bus, where an upper-page flag moves the request from the first memory to the second.

In automatic mode the selects follow the transmit queue: they drop whenever the queue has nothing left to send. In manual mode they follow the configured field alone.

Besides the select lines, the block gives two more outputs. The first is a one-cycle change strobe per line, which marks the cycle in which that line takes a new value. The second is an idle flag that is high whenever no memory is selected. The controller uses the idle flag to return its command-snooping logic to the checking state and to clear the dummy-cycle count. All outputs are registered, and each one reflects the inputs sampled at the previous clock edge.

Top module: `dual_flash_cs_mapper`

## Requirements
- R1: While rst_ni is low, every cs_n_o bit is 1, every cs_change_o bit is 0 and snoop_idle_o is 1.
- R2: The configured field cs_cfg_i is active-low. In direct mapping, a 0 in bit i selects line i, which drives cs_n_o[i] to 0 one clock edge after the inputs are sampled.
- R3: When parallel_i is 1, only cs_cfg_i[0] is used, and its selection is copied to both line 0 and line 1. Any higher lines are deselected.
- R4: When parallel_i is 0 and both stacked_i and upper_page_i are 1, the selection from cs_cfg_i[0] drives line 1 only, and line 0 is deselected. Parallel mode takes priority over this mapping.
- R5: If stacked_i is 1 with upper_page_i at 0, or upper_page_i is 1 with stacked_i at 0, the mapping stays direct.
- R6: When manual_i is 0 and tx_empty_i is 1, all lines are deselected. When manual_i is 1, tx_empty_i has no effect on the outputs.
- R7: cs_change_o[i] is 1 for exactly the one cycle in which cs_n_o[i] first shows a new value, and 0 otherwise.
- R8: snoop_idle_o is 1 exactly when every cs_n_o bit is 1, and it changes in the same cycle as the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_cfg_i | input | CS_W | Configured select field, active low |
| manual_i | input | 1 | 1 = manual select, 0 = follow transmit queue |
| parallel_i | input | 1 | Two memories wired in parallel |
| stacked_i | input | 1 | Two memories stacked on one bus |
| upper_page_i | input | 1 | Upper page of stacked pair addressed |
| tx_empty_i | input | 1 | Transmit queue empty |
| cs_n_o | output | CS_W | Physical select lines, active low |
| cs_change_o | output | CS_W | One-cycle strobe per line on a change |
| snoop_idle_o | output | 1 | No memory selected; resets snoop state |

## Verification
The hardest situations to reach are those where several mode flags overlap. One is parallel and stacked-upper requested together, where priority decides the result. Another is automatic mode with an empty queue masking a field that would otherwise select a line. The stimulus table steps through these overlaps one after another, so each row is also a transition from the row before it. That lets the change strobe and the idle flag be checked against the line-state difference between rows. A reset applied in the middle of the run checks that the lines return high without waiting for a clock edge.

// File: rtl/cs_map_pkg.sv
package cs_map_pkg;
  typedef enum logic [1:0] {
    MAP_DIRECT = 2'd0,
    MAP_MIRROR = 2'd1,
    MAP_UPPER  = 2'd2
  } map_mode_e;
endpackage

// File: rtl/cs_mode_decode.sv
module cs_mode_decode
  import cs_map_pkg::*;
(
  input  logic      parallel_i,
  input  logic      stacked_i,
  input  logic      upper_page_i,
  output map_mode_e mode_o
);
  // parallel wins over stacked upper page
  always_comb begin
    if (parallel_i)                     mode_o = MAP_MIRROR;
    else if (stacked_i && upper_page_i) mode_o = MAP_UPPER;
    else                                mode_o = MAP_DIRECT;
  end
endmodule

// File: rtl/cs_field_remap.sv
module cs_field_remap
  import cs_map_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic [CS_W-1:0] cfg_n_i,
  input  map_mode_e       mode_i,
  output logic [CS_W-1:0] sel_o
);
  logic [CS_W-1:0] req;
  assign req = ~cfg_n_i;

  for (genvar i = 0; i < CS_W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      always_comb begin
        unique case (mode_i)
          MAP_DIRECT: sel_o[i] = req[0];
          MAP_MIRROR: sel_o[i] = req[0];
          default:    sel_o[i] = 1'b0;
        endcase
      end
    end else if (i == 1) begin : g_hi
      always_comb begin
        unique case (mode_i)
          MAP_DIRECT: sel_o[i] = req[1];
          default:    sel_o[i] = req[0];
        endcase
      end
    end else begin : g_rest
      assign sel_o[i] = (mode_i == MAP_DIRECT) ? req[i] : 1'b0;
    end
  end
endmodule

// File: rtl/cs_auto_gate.sv
module cs_auto_gate #(
  parameter int CS_W = 2
) (
  input  logic [CS_W-1:0] sel_i,
  input  logic            manual_i,
  input  logic            tx_empty_i,
  output logic [CS_W-1:0] sel_o
);
  logic drop;
  assign drop  = !manual_i && tx_empty_i;
  assign sel_o = drop ? '0 : sel_i;
endmodule

// File: rtl/cs_state_reg.sv
module cs_state_reg #(
  parameter int CS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CS_W-1:0] sel_d_i,
  output logic [CS_W-1:0] cs_n_o,
  output logic [CS_W-1:0] change_o,
  output logic            idle_o
);
  logic [CS_W-1:0] sel_q, chg_q;
  logic            idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      chg_q  <= '0;
      idle_q <= 1'b1;
    end else begin
      sel_q  <= sel_d_i;
      chg_q  <= sel_d_i ^ sel_q;
      idle_q <= ~|sel_d_i;
    end
  end

  assign cs_n_o   = ~sel_q;
  assign change_o = chg_q;
  assign idle_o   = idle_q;
endmodule

// File: rtl/dual_flash_cs_mapper.sv
module dual_flash_cs_mapper
  import cs_map_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CS_W-1:0] cs_cfg_i,
  input  logic            manual_i,
  input  logic            parallel_i,
  input  logic            stacked_i,
  input  logic            upper_page_i,
  input  logic            tx_empty_i,
  output logic [CS_W-1:0] cs_n_o,
  output logic [CS_W-1:0] cs_change_o,
  output logic            snoop_idle_o
);
  map_mode_e       mode;
  logic [CS_W-1:0] sel_map, sel_gated;

  cs_mode_decode u_mode (
    .parallel_i  (parallel_i),
    .stacked_i   (stacked_i),
    .upper_page_i(upper_page_i),
    .mode_o      (mode)
  );

  cs_field_remap #(.CS_W(CS_W)) u_remap (
    .cfg_n_i(cs_cfg_i),
    .mode_i (mode),
    .sel_o  (sel_map)
  );

  cs_auto_gate #(.CS_W(CS_W)) u_gate (
    .sel_i     (sel_map),
    .manual_i  (manual_i),
    .tx_empty_i(tx_empty_i),
    .sel_o     (sel_gated)
  );

  cs_state_reg #(.CS_W(CS_W)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_d_i (sel_gated),
    .cs_n_o  (cs_n_o),
    .change_o(cs_change_o),
    .idle_o  (snoop_idle_o)
  );
endmodule

// File: rtl/dual_flash_cs_mapper_chk.sv
module dual_flash_cs_mapper_chk #(
  parameter int CS_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            manual_i,
  input logic            parallel_i,
  input logic            stacked_i,
  input logic            upper_page_i,
  input logic            tx_empty_i,
  input logic [CS_W-1:0] cs_n_o,
  input logic [CS_W-1:0] cs_change_o,
  input logic            snoop_idle_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (&cs_n_o && cs_change_o == '0 && snoop_idle_o);
    end
  end

  a_r3_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parallel_i |=> (cs_n_o[0] == cs_n_o[1]));

  a_r4_upper_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!parallel_i && stacked_i && upper_page_i) |=> cs_n_o[0]);

  a_r6_auto_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!manual_i && tx_empty_i) |=> (&cs_n_o));

  a_r7_change_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cs_change_o == (cs_n_o ^ $past(cs_n_o))));

  a_r8_idle_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_idle_o == (&cs_n_o));
endmodule

bind dual_flash_cs_mapper dual_flash_cs_mapper_chk #(.CS_W(CS_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .manual_i    (manual_i),
  .parallel_i  (parallel_i),
  .stacked_i   (stacked_i),
  .upper_page_i(upper_page_i),
  .tx_empty_i  (tx_empty_i),
  .cs_n_o      (cs_n_o),
  .cs_change_o (cs_change_o),
  .snoop_idle_o(snoop_idle_o)
);

// File: tb/dual_flash_cs_mapper_tb_top.sv
module dual_flash_cs_mapper_tb_top;
  localparam int CS_W = 2;
  localparam int NV   = 13;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [CS_W-1:0] cs_cfg_i = '1;
  logic            manual_i = 1'b1;
  logic            parallel_i = 1'b0;
  logic            stacked_i = 1'b0;
  logic            upper_page_i = 1'b0;
  logic            tx_empty_i = 1'b0;
  logic [CS_W-1:0] cs_n_o, cs_change_o;
  logic            snoop_idle_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  dual_flash_cs_mapper #(.CS_W(CS_W)) dut_i (.*);

  // {cfg[1:0], manual, parallel, stacked, upper, tx_empty, exp_sel[1:0]}
  localparam logic [8:0] VEC [NV] = '{
    9'b10_1_0_0_0_1_01, // R2 direct line 0; R6 manual ignores empty
    9'b00_1_0_0_0_0_11, // R2 both lines
    9'b10_1_1_0_0_0_11, // R3 mirror
    9'b01_1_1_0_0_0_00, // R3 bit1 ignored
    9'b10_1_0_1_1_0_10, // R4 moved to line 1
    9'b10_1_0_1_0_0_01, // R5 stacked, lower page
    9'b10_1_0_0_1_0_01, // R5 upper without stacked
    9'b10_0_0_0_0_1_00, // R6 auto, empty
    9'b10_0_0_0_0_0_01, // R6 auto, data pending
    9'b10_1_1_1_1_0_11, // R4 parallel has priority
    9'b11_1_0_0_0_0_00, // R2 none selected
    9'b00_1_0_1_1_0_10, // R4 only bit 0 used
    9'b00_1_0_1_1_0_10  // R7 no change on repeat
  };
  localparam int VREQ [NV] = '{2, 2, 3, 3, 4, 5, 5, 6, 6, 4, 2, 4, 7};

  task automatic check(input string req, input string what,
                       input logic [CS_W:0] act, input logic [CS_W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [CS_W-1:0] prev_sel;
    logic [CS_W-1:0] exp_sel;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", "cs_n", {1'b0, cs_n_o}, 3'b011);
    check("R1", "change", {1'b0, cs_change_o}, 3'b000);
    check("R1", "idle", {2'b00, snoop_idle_o}, 3'b001);
    rst_ni = 1'b1;
    prev_sel = '0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      {cs_cfg_i, manual_i, parallel_i, stacked_i, upper_page_i, tx_empty_i} = VEC[k][8:2];
      exp_sel = VEC[k][1:0];
      @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("R%0d", VREQ[k]), "cs_n", {1'b0, cs_n_o}, {1'b0, ~exp_sel});
      check("R7", "change", {1'b0, cs_change_o}, {1'b0, exp_sel ^ prev_sel});
      check("R8", "idle", {2'b00, snoop_idle_o}, {2'b00, exp_sel == '0});
      prev_sel = exp_sel;
    end

    // R7 strobe lasts one cycle only
    @(negedge clk_i);
    cs_cfg_i = 2'b11; stacked_i = 1'b0; upper_page_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R7", "strobe on", {1'b0, cs_change_o}, 3'b010);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R7", "strobe off", {1'b0, cs_change_o}, 3'b000);

    // R6 toggling tx_empty in manual mode leaves lines alone
    cs_cfg_i = 2'b10; manual_i = 1'b1; tx_empty_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    tx_empty_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R6", "manual hold", {1'b0, cs_n_o}, 3'b010);
    check("R6", "manual no strobe", {1'b0, cs_change_o}, 3'b000);

    // R1 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    check("R1", "async cs_n", {1'b0, cs_n_o}, 3'b011);
    check("R1", "async idle", {2'b00, snoop_idle_o}, 3'b001);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule